// File: doc/BRIEF.md
# Parity Error Counter Bank

This block tallies parity errors found while a data buffer is being unloaded to a host. A one-cycle pulse on the error input stands for one detected error. Each such pulse adds one to three counters: buffer errors, byte errors, and overrun/underrun events. All three counters are 8 bits wide and stop at 255 instead of wrapping around. Each error also lights a sticky parity flag, which the host reads as bit 28 of its instruction status word.

Every error also produces a pair of one-cycle strobes, one for buffer errors and one for byte errors, on consecutive cycles. An order-select input picks which strobe comes first. The order is sampled when the pair begins. An error that arrives while a pair is still running is queued. Its pair starts on the cycle right after the running pair ends.

The counters and the flag keep their values across repeated parity test runs, so counts can build up until they reach full scale. They return to zero only on one of three clearing events: a master clear, a write or read instruction, or a test instruction other than the parity test. The reset input is asynchronous and active low, and it is released synchronously through two flops. The block becomes active two clock edges after the reset input goes high.

Top module: `parity_err_tally`

## Requirements
- R1: After reset, all three counters read 0, the parity flag is 0, and both strobes are low.
- R2: An error sampled high at a clock edge raises each of the three counters by exactly one, visible after that same edge, unless a clear is present in that cycle.
- R3: With order select 1 when a pair starts, the buffer strobe is high in the cycle after the starting edge, and the byte strobe is high in the cycle after that.
- R4: With order select 0 when a pair starts, the byte strobe comes first and the buffer strobe comes in the following cycle.
- R5: Each strobe lasts exactly one cycle, the two strobes are never high together, and a lone error produces exactly one pulse on each strobe.
- R6: An error that arrives during a running pair is queued, up to 15 pending errors. Its pair begins in the cycle right after the second strobe of the running pair, so the number of pairs equals the number of errors.
- R7: The counters saturate at 255. Further errors leave them at 255.
- R8: The parity flag becomes 1 after the first error and stays 1 without a clear.
- R9: Any one of the master clear, write/read instruction, or other-test inputs sampled high at an edge sets all counters and the flag to 0 after that edge. A clear wins over an error in the same cycle, but the strobe pair for that error is still issued.
- R10: Without a clear, the counters never decrease. Idle cycles and repeated test runs keep the accumulated counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| perr_i | input | 1 | One pulse per detected parity error |
| buf_first_i | input | 1 | Order select: 1 = buffer strobe first, 0 = byte strobe first |
| mclr_i | input | 1 | Master clear event |
| xfer_instr_i | input | 1 | Write or read instruction received |
| other_test_i | input | 1 | A test instruction other than the parity test received |
| buf_stb_o | output | 1 | Buffer error strobe |
| byte_stb_o | output | 1 | Byte error strobe |
| buf_err_cnt_o | output | 8 | Buffer error count |
| byte_err_cnt_o | output | 8 | Byte error count |
| ovun_cnt_o | output | 8 | Overrun/underrun count |
| parity_flag_o | output | 1 | Sticky parity flag (status word bit 28) |

## Verification
If the queue depth is corrupted, the wrong number of strobe pairs appears. The fault shows on the strobe outputs one to two cycles after the queue should have drained or kept going. A wrong latched order value makes the pair come out reversed in the very first strobe cycle. A counter that wraps, misses a clear, or fails to count shows a wrong value on its output port in the cycle after the error or clear edge. The three counters are compared with one another and with a count kept by the bench, so any single bad lane stands out.

// File: rtl/perr_pkg.sv
package perr_pkg;
  localparam int NUM_CNT = 3;
  localparam int IDX_BUF  = 0;
  localparam int IDX_BYTE = 1;
  localparam int IDX_OVUN = 2;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_FIRST  = 2'd1,
    SEQ_SECOND = 2'd2
  } seq_state_e;
endpackage

// File: rtl/perr_rst_sync.sv
module perr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/perr_strobe_seq.sv
module perr_strobe_seq
  import perr_pkg::*;
#(
  parameter int PEND_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic err_i,
  input  logic order_i,
  output logic buf_stb_o,
  output logic byte_stb_o
);
  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  seq_state_e        state_q, state_d;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic              ord_q, ord_d;
  logic              seq_en;
  logic              in_first, in_second;

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    ord_d   = ord_q;
    unique case (state_q)
      SEQ_IDLE: begin
        if (err_i) begin
          state_d = SEQ_FIRST;
          ord_d   = order_i;
        end
      end
      SEQ_FIRST: begin
        state_d = SEQ_SECOND;
        if (err_i && (pend_q != PEND_MAX)) begin
          pend_d = pend_q + 1'b1;
        end
      end
      SEQ_SECOND: begin
        if (pend_q != '0) begin
          state_d = SEQ_FIRST;
          ord_d   = order_i;
          if (!err_i) begin
            pend_d = pend_q - 1'b1;
          end
        end else if (err_i) begin
          state_d = SEQ_FIRST;
          ord_d   = order_i;
        end else begin
          state_d = SEQ_IDLE;
        end
      end
      default: begin
        state_d = SEQ_IDLE;
        pend_d  = '0;
      end
    endcase
  end

  assign seq_en = (state_q != SEQ_IDLE) || err_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      pend_q  <= '0;
      ord_q   <= 1'b0;
    end else if (seq_en) begin
      state_q <= state_d;
      pend_q  <= pend_d;
      ord_q   <= ord_d;
    end
  end

  assign in_first   = (state_q == SEQ_FIRST);
  assign in_second  = (state_q == SEQ_SECOND);
  assign buf_stb_o  = ord_q ? in_first  : in_second;
  assign byte_stb_o = ord_q ? in_second : in_first;

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(buf_stb_o && byte_stb_o));

  // R3
  buf_then_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_stb_o && ord_q) |=> (byte_stb_o && !buf_stb_o));

  // R4
  byte_then_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_stb_o && !ord_q) |=> (buf_stb_o && !byte_stb_o));

  // R6
  queue_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_second && (pend_q != '0)) |=> (buf_stb_o || byte_stb_o));
endmodule

// File: rtl/perr_sat_counter.sv
module perr_sat_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (inc_i && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  assign cnt_en = clr_i || inc_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

  // R7
  sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_q == CNT_MAX) && !clr_i) |=> (cnt_q == CNT_MAX));

  // R10
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> (cnt_q >= $past(cnt_q)));

  // R9
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/perr_cnt_bank.sv
module perr_cnt_bank
  import perr_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr_i,
  input  logic                          err_i,
  output logic [NUM_CNT-1:0][CNT_W-1:0] cnt_o
);
  for (genvar g = 0; g < NUM_CNT; g++) begin : g_lane
    perr_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (clr_i),
      .inc_i (err_i),
      .cnt_o (cnt_o[g])
    );
  end

  // R2
  lanes_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_o[IDX_BUF] == cnt_o[IDX_BYTE]) && (cnt_o[IDX_BYTE] == cnt_o[IDX_OVUN]));
endmodule

// File: rtl/perr_sticky_flag.sv
module perr_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic set_i,
  output logic flag_o
);
  logic flag_q, flag_d, flag_en;

  always_comb begin
    flag_d = flag_q;
    if (clr_i) begin
      flag_d = 1'b0;
    end else if (set_i) begin
      flag_d = 1'b1;
    end
  end

  assign flag_en = clr_i || set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !clr_i) |=> flag_q);

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i && !clr_i) |=> flag_q);
endmodule

// File: rtl/parity_err_tally.sv
module parity_err_tally
  import perr_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int PEND_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             perr_i,
  input  logic             buf_first_i,
  input  logic             mclr_i,
  input  logic             xfer_instr_i,
  input  logic             other_test_i,
  output logic             buf_stb_o,
  output logic             byte_stb_o,
  output logic [CNT_W-1:0] buf_err_cnt_o,
  output logic [CNT_W-1:0] byte_err_cnt_o,
  output logic [CNT_W-1:0] ovun_cnt_o,
  output logic             parity_flag_o
);
  logic                          rst_sync_n;
  logic                          clr_any;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_all;

  assign clr_any = mclr_i || xfer_instr_i || other_test_i;

  perr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  perr_strobe_seq #(.PEND_W(PEND_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .err_i      (perr_i),
    .order_i    (buf_first_i),
    .buf_stb_o  (buf_stb_o),
    .byte_stb_o (byte_stb_o)
  );

  perr_cnt_bank #(.CNT_W(CNT_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr_i (clr_any),
    .err_i (perr_i),
    .cnt_o (cnt_all)
  );

  perr_sticky_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr_i  (clr_any),
    .set_i  (perr_i),
    .flag_o (parity_flag_o)
  );

  assign buf_err_cnt_o  = cnt_all[IDX_BUF];
  assign byte_err_cnt_o = cnt_all[IDX_BYTE];
  assign ovun_cnt_o     = cnt_all[IDX_OVUN];

  // R9
  clr_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clr_any |=> !parity_flag_o);
endmodule

// File: tb/tb_parity_err_tally.sv
module tb_parity_err_tally;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       perr_i, buf_first_i, mclr_i, xfer_instr_i, other_test_i;
  logic       buf_stb_o, byte_stb_o, parity_flag_o;
  logic [7:0] buf_err_cnt_o, byte_err_cnt_o, ovun_cnt_o;

  int n_checks = 0;
  int n_fail   = 0;
  int exp_cnt  = 0;

  always #2.5 clk = ~clk;

  parity_err_tally dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .perr_i         (perr_i),
    .buf_first_i    (buf_first_i),
    .mclr_i         (mclr_i),
    .xfer_instr_i   (xfer_instr_i),
    .other_test_i   (other_test_i),
    .buf_stb_o      (buf_stb_o),
    .byte_stb_o     (byte_stb_o),
    .buf_err_cnt_o  (buf_err_cnt_o),
    .byte_err_cnt_o (byte_err_cnt_o),
    .ovun_cnt_o     (ovun_cnt_o),
    .parity_flag_o  (parity_flag_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_counts(input string req, input int exp);
    chk({req, " buf count"},  int'(buf_err_cnt_o),  exp);
    chk({req, " byte count"}, int'(byte_err_cnt_o), exp);
    chk({req, " ovun count"}, int'(ovun_cnt_o),     exp);
  endtask

  task automatic strobes(input string req, input int exp_buf, input int exp_byte);
    chk({req, " buf strobe"},  int'(buf_stb_o),  exp_buf);
    chk({req, " byte strobe"}, int'(byte_stb_o), exp_byte);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
  endtask

  task automatic t_reset;
    chk_counts("R1", 0);
    chk("R1 flag", int'(parity_flag_o), 0);
    strobes("R1", 0, 0);
  endtask

  // Lone error, buffer strobe first
  task automatic t_order_buf_first;
    buf_first_i = 1'b1;
    perr_i = 1'b1;
    @(negedge clk);
    perr_i = 1'b0;
    buf_first_i = 1'b0;  // order latched at pair start: change has no effect
    exp_cnt++;
    chk_counts("R2", exp_cnt);
    chk("R8 flag set", int'(parity_flag_o), 1);
    strobes("R3 first", 1, 0);
    @(negedge clk);
    strobes("R3 second", 0, 1);
    @(negedge clk);
    strobes("R5 idle after pair", 0, 0);
    chk_counts("R5 no extra count", exp_cnt);
  endtask

  task automatic t_order_byte_first;
    buf_first_i = 1'b0;
    perr_i = 1'b1;
    @(negedge clk);
    perr_i = 1'b0;
    buf_first_i = 1'b1;
    exp_cnt++;
    chk_counts("R2", exp_cnt);
    strobes("R4 first", 0, 1);
    @(negedge clk);
    strobes("R4 second", 1, 0);
    @(negedge clk);
    strobes("R5 idle", 0, 0);
    buf_first_i = 1'b0;
  endtask

  // Second error arrives during the first strobe
  task automatic t_queue;
    int nb, ny;
    buf_first_i = 1'b1;
    perr_i = 1'b1;
    @(negedge clk);
    strobes("R6 pair1 first", 1, 0);
    @(negedge clk);
    perr_i = 1'b0;
    exp_cnt += 2;
    chk_counts("R6 two counted", exp_cnt);
    strobes("R6 pair1 second", 0, 1);
    @(negedge clk);
    strobes("R6 pair2 first", 1, 0);
    @(negedge clk);
    strobes("R6 pair2 second", 0, 1);
    @(negedge clk);
    strobes("R6 drained", 0, 0);
    // burst of 5 back-to-back errors gives 5 pairs
    nb = 0; ny = 0;
    perr_i = 1'b1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      nb += int'(buf_stb_o); ny += int'(byte_stb_o);
    end
    perr_i = 1'b0;
    exp_cnt += 5;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      nb += int'(buf_stb_o); ny += int'(byte_stb_o);
    end
    chk("R6 burst buf pulses", nb, 5);
    chk("R6 burst byte pulses", ny, 5);
    chk_counts("R2 burst", exp_cnt);
  endtask

  task automatic t_persist;
    idle(20);
    chk_counts("R10 persist idle", exp_cnt);
    chk("R8 flag persist", int'(parity_flag_o), 1);
  endtask

  task automatic t_clear(input int which);
    case (which)
      0: mclr_i = 1'b1;
      1: xfer_instr_i = 1'b1;
      default: other_test_i = 1'b1;
    endcase
    @(negedge clk);
    mclr_i = 1'b0; xfer_instr_i = 1'b0; other_test_i = 1'b0;
    exp_cnt = 0;
    chk_counts($sformatf("R9 clear src%0d", which), 0);
    chk($sformatf("R9 flag clr src%0d", which), int'(parity_flag_o), 0);
  endtask

  // Error and clear in the same cycle
  task automatic t_clear_wins;
    perr_i = 1'b1; buf_first_i = 1'b1; mclr_i = 1'b1;
    @(negedge clk);
    perr_i = 1'b0; mclr_i = 1'b0;
    chk_counts("R9 clear wins", 0);
    chk("R9 flag clear wins", int'(parity_flag_o), 0);
    strobes("R9 pair still issued", 1, 0);
    @(negedge clk);
    strobes("R9 pair second", 0, 1);
    @(negedge clk);
  endtask

  task automatic t_saturate;
    perr_i = 1'b1;
    for (int i = 0; i < 260; i++) @(negedge clk);
    perr_i = 1'b0;
    chk_counts("R7 saturate", 255);
    idle(40);
    strobes("R6 queue drained", 0, 0);
    chk_counts("R7 hold", 255);
    perr_i = 1'b1;
    @(negedge clk);
    perr_i = 1'b0;
    chk_counts("R7 no wrap", 255);
    idle(4);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    report();
    $finish;
  end

  initial begin : main
    rst_n = 1'b0;
    perr_i = 1'b0; buf_first_i = 1'b0;
    mclr_i = 1'b0; xfer_instr_i = 1'b0; other_test_i = 1'b0;
    idle(5);
    rst_n = 1'b1;
    idle(5);
    t_reset();
    t_order_buf_first();
    t_order_byte_first();
    t_queue();
    t_persist();
    t_clear(0);
    t_order_buf_first();
    t_clear(1);
    t_order_byte_first();
    t_clear(2);
    t_clear_wins();
    t_saturate();
    t_clear(0);
    report();
    $finish;
  end
endmodule